// File: doc/BRIEF.md
# Row-End Marker Pulse Generator

This block paces a sampled-audio memory sequencer one memory row at a time. It counts enable ticks from a fixed timebase. For each row it drives a marker whose output stage is open-drain style. The marker is released (high) for most of the row. It is pulled low for a short window that closes the row. The current row index advances when that low window ends, and a one-cycle strobe marks the same cycle.

There are two row-timing modes, each with its own high/low split. Normal record/playback mode uses 15872 high ticks plus 512 low ticks. Fast-scan cueing mode uses 32 high ticks plus 1 low tick. A record start in normal mode stretches only the first high phase, by a parameterised number of ticks. The row index wraps at a selectable memory size. At the wrap a one-cycle end-of-memory pulse is raised, and the generator then halts or continues depending on a wrap-enable input. A synchronous stop returns the block to idle at any point.

Top module: `rowmark_gen`

## Requirements
- R1: After reset the marker is released (`markLowEn`=0), `rowIdx`=0, and `rowStrobe` and `endOfMem` are 0.
- R2: In normal mode (`cue`=0 at start), each row is 15872 ticks with `markLowEn`=0 followed by 512 ticks with `markLowEn`=1.
- R3: In cueing mode (`cue`=1 at start), each row is 32 ticks released followed by 1 tick pulled low.
- R4: A start with `recStart`=1 in normal mode lengthens the first high phase by REC_EXTRA ticks (default 32, giving 15904). Later rows are normal. A playback start (`recStart`=0) or a start in cueing mode gets no extension.
- R5: At the end of each low phase, `rowIdx` increments and `rowStrobe` is 1 for exactly that one cycle, with the marker released in the same cycle.
- R6: The row count is 256 << `sizeSel` (0→256, 1→512, 2→1024, 3→2048). After the last row, `rowIdx` returns to 0.
- R7: `endOfMem` is 1 for one cycle, together with the `rowStrobe` that wraps `rowIdx` to 0. With `wrapEn`=1 the rows continue. With `wrapEn`=0 the generator goes idle and produces no further low phases or strobes.
- R8: `stop`=1 puts the block into idle at the next clock edge. The marker is released, no strobe is produced, and `rowIdx` keeps its value.
- R9: A change of `cue` while running takes effect only from the next row boundary. The row in progress keeps its timing.
- R10: Counting advances only on cycles with `tick`=1. With `tick` held at 0 the phase and row do not change.
- R11: `start` is ignored while a row sequence is running. The row index does not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one per sample tick |
| start | input | 1 | Start pulse, accepted only while idle |
| recStart | input | 1 | Qualifies `start` as a record start |
| cue | input | 1 | Mode request: 1 = cueing, 0 = normal |
| stop | input | 1 | Synchronous return to idle |
| wrapEn | input | 1 | 1 = continue after the memory wrap, 0 = halt |
| sizeSel | input | 2 | Memory size select (256 << sizeSel rows) |
| markLowEn | output | 1 | Open-drain pull-down enable for the marker |
| rowIdx | output | 11 | Current row index |
| rowStrobe | output | 1 | One-cycle pulse as the row advances |
| endOfMem | output | 1 | One-cycle pulse as the row index wraps |

## Verification
The embedded assertions check several things on every cycle. Each strobe must follow a low phase, and each must step the row by one or wrap it to zero. The end-of-memory pulse must coincide with a wrap to row 0. A stop must release the marker and freeze the row. The mode latched for a row must stay constant within that row, and a cueing-mode low phase must last a single tick. Exact phase lengths in ticks, the record-start stretch and the ignored start can only be shown by the bench's scenarios, which count samples across whole rows. The same holds for halting versus continuing at the wrap and for the delayed mode switch.

// File: rtl/rowmark_pkg.sv
package rowmark_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rowClr;
    logic rowAdv;
  } dpCtl_t;
endpackage

// File: rtl/rowmark_dp.sv
module rowmark_dp
  import rowmark_pkg::*;
#(
  parameter int CW = 15,
  parameter int BASE_LOG2 = 8,
  parameter int SIZE_STEPS = 4,
  localparam int RW = BASE_LOG2 + SIZE_STEPS - 1,
  localparam int SW = (SIZE_STEPS > 1) ? $clog2(SIZE_STEPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [SW-1:0] sizeSel,
  output logic [CW-1:0] cnt,
  output logic [RW-1:0] rowIdx,
  output logic          rowLast
);
  logic [RW-1:0] lastRow;

  always_comb begin
    lastRow = (RW'(1) << (BASE_LOG2 + int'(sizeSel))) - RW'(1);
    rowLast = (rowIdx == lastRow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + CW'(1);
      if (ctl.rowClr)      rowIdx <= '0;
      else if (ctl.rowAdv) rowIdx <= rowLast ? '0 : rowIdx + RW'(1);
    end
  end
endmodule

// File: rtl/rowmark_ctl.sv
module rowmark_ctl
  import rowmark_pkg::*;
#(
  parameter int CW = 15,
  parameter int HI_NORM = 15872,
  parameter int LO_NORM = 512,
  parameter int HI_CUE = 32,
  parameter int LO_CUE = 1,
  parameter int REC_EXTRA = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          start,
  input  logic          recStart,
  input  logic          cue,
  input  logic          stop,
  input  logic          wrapEn,
  input  logic [CW-1:0] cnt,
  input  logic          rowLast,
  output dpCtl_t        ctl,
  output logic          markLowEn,
  output logic          rowStrobe,
  output logic          endOfMem
);
  phase_t        phase, phaseNxt;
  logic          cueM, extraOn;
  logic [CW-1:0] hiLen, loLen;
  logic          hiDone, loDone, accept;

  always_comb begin
    if (cueM)         hiLen = CW'(HI_CUE);
    else if (extraOn) hiLen = CW'(HI_NORM + REC_EXTRA);
    else              hiLen = CW'(HI_NORM);
    loLen  = cueM ? CW'(LO_CUE) : CW'(LO_NORM);
    hiDone = tick && (cnt == hiLen - CW'(1));
    loDone = tick && (cnt == loLen - CW'(1));
    accept = (phase == PH_IDLE) && start && !stop;
  end

  always_comb begin
    ctl      = '0;
    phaseNxt = phase;
    case (phase)
      PH_IDLE: if (accept) begin
        phaseNxt   = PH_HIGH;
        ctl.cntClr = 1'b1;
        ctl.rowClr = 1'b1;
      end
      PH_HIGH: begin
        if (stop) phaseNxt = PH_IDLE;
        else if (hiDone) begin
          phaseNxt   = PH_LOW;
          ctl.cntClr = 1'b1;
        end else if (tick) ctl.cntInc = 1'b1;
      end
      PH_LOW: begin
        if (stop) phaseNxt = PH_IDLE;
        else if (loDone) begin
          ctl.cntClr = 1'b1;
          ctl.rowAdv = 1'b1;
          phaseNxt   = (rowLast && !wrapEn) ? PH_IDLE : PH_HIGH;
        end else if (tick) ctl.cntInc = 1'b1;
      end
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cueM      <= 1'b0;
      extraOn   <= 1'b0;
      rowStrobe <= 1'b0;
      endOfMem  <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      rowStrobe <= ctl.rowAdv;
      endOfMem  <= ctl.rowAdv && rowLast;
      if (accept) begin
        cueM    <= cue;
        extraOn <= recStart && !cue;
      end else if (ctl.rowAdv) begin
        cueM    <= cue;
        extraOn <= 1'b0;
      end
    end
  end

  assign markLowEn = (phase == PH_LOW);

  // R9: the latched mode holds for the whole row
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !ctl.rowAdv) |=> $stable(cueM));

  // R3: a cueing low phase lasts a single tick
  a_r3_cue_low_one_tick: assert property (@(posedge clk) disable iff (!rstN)
    (LO_CUE == 1 && phase == PH_LOW && cueM && tick && !stop) |=> phase != PH_LOW);
endmodule

// File: rtl/rowmark_gen.sv
module rowmark_gen
  import rowmark_pkg::*;
#(
  parameter int HI_NORM = 15872,
  parameter int LO_NORM = 512,
  parameter int HI_CUE = 32,
  parameter int LO_CUE = 1,
  parameter int REC_EXTRA = 32,
  parameter int BASE_LOG2 = 8,
  parameter int SIZE_STEPS = 4,
  localparam int CW = $clog2(HI_NORM + REC_EXTRA + LO_NORM + 1),
  localparam int RW = BASE_LOG2 + SIZE_STEPS - 1,
  localparam int SW = (SIZE_STEPS > 1) ? $clog2(SIZE_STEPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          start,
  input  logic          recStart,
  input  logic          cue,
  input  logic          stop,
  input  logic          wrapEn,
  input  logic [SW-1:0] sizeSel,
  output logic          markLowEn,
  output logic [RW-1:0] rowIdx,
  output logic          rowStrobe,
  output logic          endOfMem
);
  dpCtl_t        ctlBus;
  logic [CW-1:0] cnt;
  logic          rowLast;

  rowmark_ctl #(
    .CW(CW), .HI_NORM(HI_NORM), .LO_NORM(LO_NORM),
    .HI_CUE(HI_CUE), .LO_CUE(LO_CUE), .REC_EXTRA(REC_EXTRA)
  ) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .start(start), .recStart(recStart),
    .cue(cue), .stop(stop), .wrapEn(wrapEn), .cnt(cnt), .rowLast(rowLast),
    .ctl(ctlBus), .markLowEn(markLowEn), .rowStrobe(rowStrobe), .endOfMem(endOfMem)
  );

  rowmark_dp #(.CW(CW), .BASE_LOG2(BASE_LOG2), .SIZE_STEPS(SIZE_STEPS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .sizeSel(sizeSel),
    .cnt(cnt), .rowIdx(rowIdx), .rowLast(rowLast)
  );

  // R5: a strobe closes a low phase and steps the row by one or wraps it
  a_r5_strobe_after_low: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |-> ($past(markLowEn) && !markLowEn));
  a_r5_strobe_steps_row: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |-> (rowIdx == RW'($past(rowIdx) + RW'(1)) || rowIdx == '0));

  // R7: end-of-memory only with a wrap to row 0
  a_r7_eom_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    endOfMem |-> (rowStrobe && rowIdx == '0));

  // R8: stop releases the marker and freezes the row
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!markLowEn && !rowStrobe && $stable(rowIdx)));
endmodule

// File: tb/sim_rowmark_gen.sv
module sim_rowmark_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        start = 1'b0;
  logic        recStart = 1'b0;
  logic        cue = 1'b0;
  logic        stop = 1'b0;
  logic        wrapEn = 1'b0;
  logic [1:0]  sizeSel = 2'd0;
  logic        markLowEn;
  logic [10:0] rowIdx;
  logic        rowStrobe;
  logic        endOfMem;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rowmark_gen u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .start(start), .recStart(recStart),
    .cue(cue), .stop(stop), .wrapEn(wrapEn), .sizeSel(sizeSel),
    .markLowEn(markLowEn), .rowIdx(rowIdx), .rowStrobe(rowStrobe), .endOfMem(endOfMem)
  );

  // {cue, recStart, first high, first low, second high}
  localparam int VEC[4][5] = '{
    '{0, 0, 15872, 512, 15872},
    '{0, 1, 15904, 512, 15872},
    '{1, 0, 32, 1, 32},
    '{1, 1, 32, 1, 32}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doStop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic doStart(input bit c, input bit r);
    cue = c; recStart = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; recStart = 1'b0;
  endtask

  task automatic measureRow(output int hi, output int lo);
    hi = 0; lo = 0;
    while (markLowEn == 1'b0) begin hi++; @(negedge clk); end
    while (markLowEn == 1'b1) begin lo++; @(negedge clk); end
  endtask

  task automatic runWrap(input int sz, input bit we);
    int rows = 256 << sz;
    int seen = 0;
    doStop();
    sizeSel = sz[1:0]; wrapEn = we;
    doStart(1'b1, 1'b0);
    while (endOfMem == 1'b0) begin
      if (rowStrobe) seen++;
      @(negedge clk);
    end
    seen++;
    check(seen == rows, "R6 rows before wrap", seen, rows);
    check(rowIdx == 0 && rowStrobe, "R7 wrap to row 0 with strobe", rowIdx, 0);
    @(negedge clk);
    check(endOfMem == 1'b0, "R7 eom one cycle", endOfMem, 0);
    if (!we) begin
      int act = 0;
      for (int i = 0; i < 80; i++) begin
        if (markLowEn || rowStrobe) act++;
        @(negedge clk);
      end
      check(act == 0, "R7 halt after wrap", act, 0);
    end else begin
      while (rowStrobe == 1'b0) @(negedge clk);
      check(rowIdx == 1 && !endOfMem, "R7 continue after wrap", rowIdx, 1);
    end
  endtask

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!markLowEn && rowIdx == 0 && !rowStrobe && !endOfMem, "R1 reset state",
          {markLowEn, rowStrobe, endOfMem}, 0);

    for (int v = 0; v < 4; v++) begin
      doStop();
      doStart(VEC[v][0] != 0, VEC[v][1] != 0);
      measureRow(hi, lo);
      check(hi == VEC[v][2], VEC[v][0] != 0 ? "R3 cue high" : "R4 first high", hi, VEC[v][2]);
      check(lo == VEC[v][3], VEC[v][0] != 0 ? "R3 cue low" : "R2 normal low", lo, VEC[v][3]);
      check(rowStrobe && rowIdx == 1 && !markLowEn, "R5 strobe and step", rowIdx, 1);
      measureRow(hi, lo);
      check(hi == VEC[v][4], "R2 second-row high", hi, VEC[v][4]);
      check(rowIdx == 2, "R5 second step", rowIdx, 2);
    end

    // R10: no ticks, no progress
    doStop();
    tick = 1'b0;
    doStart(1'b1, 1'b0);
    begin
      int moved = 0;
      for (int i = 0; i < 100; i++) begin
        if (markLowEn || rowStrobe || rowIdx != 0) moved++;
        @(negedge clk);
      end
      check(moved == 0, "R10 frozen without tick", moved, 0);
    end
    tick = 1'b1;
    measureRow(hi, lo);
    check(hi == 32 && lo == 1, "R10 resumes on tick", hi, 32);

    // R11: start ignored while running
    while (rowIdx != 2) @(negedge clk);
    doStart(1'b1, 1'b1);
    check(rowIdx == 2, "R11 start keeps row", rowIdx, 2);
    while (rowStrobe == 1'b0) @(negedge clk);
    check(rowIdx == 3, "R11 row continues", rowIdx, 3);

    // R8: stop during low phase
    while (markLowEn == 1'b0) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(!markLowEn && !rowStrobe && rowIdx == 3, "R8 stop releases", rowIdx, 3);
    repeat (40) @(negedge clk);
    check(!markLowEn && rowIdx == 3, "R8 stays idle", markLowEn, 0);

    // R9: mode change waits for row boundary
    doStop();
    doStart(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    cue = 1'b0;
    hi = 5;
    while (markLowEn == 1'b0) begin hi++; @(negedge clk); end
    check(hi == 32, "R9 current row keeps cue timing", hi, 32);
    while (rowStrobe == 1'b0) @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 60; i++) begin
        if (markLowEn) lows++;
        @(negedge clk);
      end
      check(lows == 0, "R9 next row normal", lows, 0);
    end

    runWrap(0, 1'b1);
    runWrap(1, 1'b0);
    runWrap(2, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule